// File: doc/BRIEF.md
# Prefix-Mode Instruction Sequencer

This block is the front end of a small 8-bit-opcode coprocessor. It keeps a single opcode byte in a pipe register. Each step it hands that byte to the execute stage and, in the same cycle, fetches the next byte from program memory. Fetching always one byte ahead gives branches a delay slot: the byte after a branch executes before the branch target does. The fetch address is the program bank joined with a 16-bit program counter, and the counter moves forward by one on every fetch.

Some opcodes are prefixes. They change state that lasts into later instructions: two mode flags and a pair of 4-bit selectors that name the source and destination registers. The block places the two mode flags above the opcode to form a 10-bit dispatch index, so the execute stage decodes from a 1024-entry space. Every opcode that is not a prefix clears the mode state and returns both selectors to register 0.

When an instruction writes register 14, the block starts a byte read from ROM at the ROM bank joined with the new value. It shows a pending flag until the byte comes back and is latched into a buffer.

Top module: `prefix_sequencer`

## Requirements
- R1: After reset, `status` is 0, `dispValid` is 0 and `romReq` is 0.
- R2: A `start` pulse loads `startPc`, and `pmAddr` then reads {`progBank`, `startPc`}. The next cycle is a fill cycle with `dispValid` at 0. After that, `dispValid` is 1, `dispIdx[7:0]` is the byte at `startPc`, and `pmAddr` points one byte further on. Each dispatch without a branch advances the low 16 bits of `pmAddr` by one.
- R3: `dispIdx` is {mode flag 2, mode flag 1, opcode}. The mode is 0 when neither flag is set, 1 for flag 1 alone, 2 for flag 2 alone, and 3 for both. `status` bit 8 holds flag 1 and bit 9 holds flag 2.
- R4: The mode prefixes set the mode flags for the next instruction and leave the selectors and bit 12 unchanged: opcode 0x3D sets only flag 1, 0x3E sets only flag 2, and 0x3F sets both.
- R5: Opcode 0x2n sets both selectors to n and sets `status` bit 12.
- R6: While bit 12 is clear, opcode 0x1n sets only the destination selector to n and opcode 0xBn sets only the source selector to n. Both are prefixes, so the mode flags are kept.
- R7: While bit 12 is set, 0x1n and 0xBn are move instructions and not prefixes. For 0x1n, `dispDst` = n and `dispSrc` is the current source. For 0xBn, `dispSrc` = n and `dispDst` is the current destination.
- R8: After any opcode that is not a prefix, both mode flags and bit 12 are clear, and `dispSrc` and `dispDst` read 0.
- R9: When `exBranch` is high during a dispatch, the byte that follows executes next. Fetching then continues at the delay-slot address plus the sign-extended `exOffset`.
- R10: A dispatch with `exWrite` and `dispDst` = 14 raises `romReq`, with `romAddr` = {`romBank`, `exResult`}, and sets `status` bit 6. Both stay high until `romValid`. On `romValid` the byte on `romData` appears on `romBuf`, and `romReq` and bit 6 fall.
- R11: `status` bit 5 is high while the block runs. A dispatch with `exStop` is the last one: the next cycle has `dispValid` and bit 5 at 0.
- R12: A dispatch with `exWrite` whose destination is not 14 does not raise `romReq` and leaves `romBuf` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; loads the program counter |
| startPc | input | 16 | Program counter value loaded on start |
| progBank | input | 8 | Program bank, upper bits of the fetch address |
| romBank | input | 8 | ROM bank, upper bits of the buffer read address |
| pmAddr | output | 24 | Program memory fetch address |
| pmData | input | 8 | Program memory byte at `pmAddr`, same cycle |
| dispValid | output | 1 | An opcode is being dispatched this cycle |
| dispIdx | output | 10 | Dispatch index {mode flag 2, mode flag 1, opcode} |
| dispSrc | output | 4 | Source register in effect for this opcode |
| dispDst | output | 4 | Destination register in effect for this opcode |
| exWrite | input | 1 | Execute stage writes the destination register |
| exResult | input | 16 | Value written to the destination |
| exBranch | input | 1 | Dispatched opcode is a taken branch |
| exOffset | input | 8 | Signed branch offset from the delay-slot address |
| exStop | input | 1 | Dispatched opcode halts the sequencer |
| romReq | output | 1 | ROM buffer read pending |
| romAddr | output | 24 | ROM buffer read address |
| romValid | input | 1 | ROM byte on `romData` is valid |
| romData | input | 8 | ROM byte returned |
| romBuf | output | 8 | Latched ROM buffer byte |
| status | output | 16 | Flags: bit 5 run, 6 ROM pending, 8 mode 1, 9 mode 2, 12 paired-select |

## Verification
The case that is hardest to reach is the move form of 0x1n and 0xBn. It needs a 0x2n prefix immediately before, and the selector that stays unchanged must hold a non-zero value, otherwise a wrong choice would not show. The stimulus therefore places 0x25 before 0x17 and 0x28 before 0xB2 in program memory, and checks that `dispSrc` and `dispDst` each come from the correct side. The ROM buffer read is kept pending for several dispatches before `romValid` arrives, so the bench can see that the pending flag is held while unrelated opcodes run.

// File: rtl/prefix_seq_pkg.sv
package prefix_seq_pkg;
  localparam int OP_W  = 8;
  localparam int SEL_W = 4;

  localparam logic [7:0] OP_MODE1 = 8'h3D;
  localparam logic [7:0] OP_MODE2 = 8'h3E;
  localparam logic [7:0] OP_MODE3 = 8'h3F;
  localparam logic [3:0] GRP_PAIR = 4'h2;
  localparam logic [3:0] GRP_DST  = 4'h1;
  localparam logic [3:0] GRP_SRC  = 4'hB;
  localparam logic [3:0] ROMBUF_REG = 4'd14;

  // strobes from control to datapath
  typedef struct packed {
    logic             start;
    logic             fill;
    logic             step;
    logic             branch;
    logic             setMode;
    logic [1:0]       modeVal;
    logic             loadSrc;
    logic             loadDst;
    logic             setPair;
    logic             clearAll;
    logic [SEL_W-1:0] selNum;
    logic             trigRom;
  } ctrlStrobes_t;

  function automatic logic isPrefixOp(input logic [7:0] op, input logic pairFlag);
    logic modeOp;
    modeOp = (op == OP_MODE1) || (op == OP_MODE2) || (op == OP_MODE3);
    return modeOp || (op[7:4] == GRP_PAIR) ||
           (!pairFlag && ((op[7:4] == GRP_DST) || (op[7:4] == GRP_SRC)));
  endfunction
endpackage

// File: rtl/seq_control.sv
module seq_control
  import prefix_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OP_W-1:0]  pipe,
  input  logic             pairFlag,
  input  logic [SEL_W-1:0] srcSel,
  input  logic [SEL_W-1:0] dstSel,
  input  logic             exWrite,
  input  logic             exBranch,
  input  logic             exStop,
  output ctrlStrobes_t     stb,
  output logic             running,
  output logic             dispValid,
  output logic [SEL_W-1:0] dispSrc,
  output logic [SEL_W-1:0] dispDst
);
  logic filled;
  logic modeOp, pairOp, dstOp, srcOp, moveDst, moveSrc, doStep;

  assign dispValid = running && filled;
  assign doStep    = dispValid && !start;

  always_comb begin
    modeOp  = (pipe == OP_MODE1) || (pipe == OP_MODE2) || (pipe == OP_MODE3);
    pairOp  = pipe[7:4] == GRP_PAIR;
    dstOp   = pipe[7:4] == GRP_DST;
    srcOp   = pipe[7:4] == GRP_SRC;
    moveDst = dstOp && pairFlag;
    moveSrc = srcOp && pairFlag;
    dispSrc = moveSrc ? pipe[3:0] : srcSel;
    dispDst = moveDst ? pipe[3:0] : dstSel;

    stb          = '0;
    stb.start    = start;
    stb.fill     = running && !filled && !start;
    stb.step     = doStep;
    stb.branch   = doStep && exBranch;
    stb.selNum   = pipe[3:0];
    stb.setMode  = doStep && modeOp;
    stb.modeVal  = (pipe == OP_MODE1) ? 2'b01 : (pipe == OP_MODE2) ? 2'b10 : 2'b11;
    stb.loadSrc  = doStep && (pairOp || (srcOp && !pairFlag));
    stb.loadDst  = doStep && (pairOp || (dstOp && !pairFlag));
    stb.setPair  = doStep && pairOp;
    stb.clearAll = doStep && !isPrefixOp(pipe, pairFlag);
    stb.trigRom  = doStep && exWrite && (dispDst == ROMBUF_REG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      filled  <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      filled  <= 1'b0;
    end else if (stb.fill) begin
      filled <= 1'b1;
    end else if (doStep && exStop) begin
      running <= 1'b0;
      filled  <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import prefix_seq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic [PC_W-1:0]   startPc,
  input  logic [BANK_W-1:0] progBank,
  input  logic [BANK_W-1:0] romBank,
  input  logic [OP_W-1:0]   pmData,
  input  logic [PC_W-1:0]   exResult,
  input  logic [7:0]        exOffset,
  input  logic              romValid,
  input  logic [7:0]        romData,
  output logic [BANK_W+PC_W-1:0] pmAddr,
  output logic [OP_W-1:0]   pipe,
  output logic              alt1,
  output logic              alt2,
  output logic              pairFlag,
  output logic [SEL_W-1:0]  srcSel,
  output logic [SEL_W-1:0]  dstSel,
  output logic              romPend,
  output logic [BANK_W+PC_W-1:0] romAddr,
  output logic [7:0]        romBuf
);
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] offsetExt;

  assign offsetExt = {{(PC_W-8){exOffset[7]}}, exOffset};
  assign pmAddr    = {progBank, pc};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= '0;
      pipe     <= '0;
      alt1     <= 1'b0;
      alt2     <= 1'b0;
      pairFlag <= 1'b0;
      srcSel   <= '0;
      dstSel   <= '0;
    end else if (stb.start) begin
      pc       <= startPc;
      alt1     <= 1'b0;
      alt2     <= 1'b0;
      pairFlag <= 1'b0;
      srcSel   <= '0;
      dstSel   <= '0;
    end else if (stb.fill) begin
      pipe <= pmData;
      pc   <= pc + 1'b1;
    end else if (stb.step) begin
      pipe <= pmData;
      pc   <= stb.branch ? pc + offsetExt : pc + 1'b1;
      if (stb.clearAll) begin
        alt1     <= 1'b0;
        alt2     <= 1'b0;
        pairFlag <= 1'b0;
        srcSel   <= '0;
        dstSel   <= '0;
      end else begin
        if (stb.setMode) {alt2, alt1} <= stb.modeVal;
        if (stb.setPair) pairFlag <= 1'b1;
        if (stb.loadSrc) srcSel <= stb.selNum;
        if (stb.loadDst) dstSel <= stb.selNum;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romPend <= 1'b0;
      romAddr <= '0;
      romBuf  <= '0;
    end else if (stb.trigRom) begin
      romPend <= 1'b1;
      romAddr <= {romBank, exResult};
    end else if (romPend && romValid) begin
      romPend <= 1'b0;
      romBuf  <= romData;
    end
  end
endmodule

// File: rtl/prefix_sequencer.sv
module prefix_sequencer
  import prefix_seq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  localparam int FULL_W = BANK_W + PC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PC_W-1:0]   startPc,
  input  logic [BANK_W-1:0] progBank,
  input  logic [BANK_W-1:0] romBank,
  output logic [FULL_W-1:0] pmAddr,
  input  logic [7:0]        pmData,
  output logic              dispValid,
  output logic [9:0]        dispIdx,
  output logic [3:0]        dispSrc,
  output logic [3:0]        dispDst,
  input  logic              exWrite,
  input  logic [PC_W-1:0]   exResult,
  input  logic              exBranch,
  input  logic [7:0]        exOffset,
  input  logic              exStop,
  output logic              romReq,
  output logic [FULL_W-1:0] romAddr,
  input  logic              romValid,
  input  logic [7:0]        romData,
  output logic [7:0]        romBuf,
  output logic [15:0]       status
);
  ctrlStrobes_t     stb;
  logic [OP_W-1:0]  pipe;
  logic             alt1, alt2, pairFlag, running;
  logic [SEL_W-1:0] srcSel, dstSel;

  seq_control uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .pipe(pipe), .pairFlag(pairFlag),
    .srcSel(srcSel), .dstSel(dstSel), .exWrite(exWrite), .exBranch(exBranch),
    .exStop(exStop), .stb(stb), .running(running), .dispValid(dispValid),
    .dispSrc(dispSrc), .dispDst(dispDst)
  );

  seq_datapath #(.PC_W(PC_W), .BANK_W(BANK_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .startPc(startPc), .progBank(progBank),
    .romBank(romBank), .pmData(pmData), .exResult(exResult), .exOffset(exOffset),
    .romValid(romValid), .romData(romData), .pmAddr(pmAddr), .pipe(pipe),
    .alt1(alt1), .alt2(alt2), .pairFlag(pairFlag), .srcSel(srcSel),
    .dstSel(dstSel), .romPend(romReq), .romAddr(romAddr), .romBuf(romBuf)
  );

  assign dispIdx = {alt2, alt1, pipe};
  assign status  = {3'b000, pairFlag, 2'b00, alt2, alt1, 1'b0, romReq, running, 5'b00000};
endmodule

// File: rtl/prefix_sequencer_chk.sv
module prefix_sequencer_chk
  import prefix_seq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [23:0] pmAddr,
  input logic        dispValid,
  input logic [9:0]  dispIdx,
  input logic [3:0]  dispDst,
  input logic        exWrite,
  input logic        exBranch,
  input logic        exStop,
  input logic        romReq,
  input logic        romValid,
  input logic [15:0] status
);
  // R2
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !exBranch && !start) |=> (pmAddr[15:0] == $past(pmAddr[15:0]) + 16'd1));

  // R4
  mode3_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !start && dispIdx[7:0] == OP_MODE3) |=> (status[9:8] == 2'b11));

  // R8
  clear_after_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !start && !isPrefixOp(dispIdx[7:0], status[12]))
      |=> (status[9:8] == 2'b00 && !status[12]));

  // R10
  rom_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !start && exWrite && dispDst == 4'd14) |=> (romReq && status[6]));

  // R10
  rom_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (romReq && romValid && !(dispValid && !start && exWrite && dispDst == 4'd14)) |=> !romReq);

  // R11
  stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && exStop && !start) |=> (!dispValid && !status[5]));
endmodule

bind prefix_sequencer prefix_sequencer_chk uChk (
  .clk(clk), .rstN(rstN), .start(start), .pmAddr(pmAddr), .dispValid(dispValid),
  .dispIdx(dispIdx), .dispDst(dispDst), .exWrite(exWrite), .exBranch(exBranch),
  .exStop(exStop), .romReq(romReq), .romValid(romValid), .status(status)
);

// File: tb/prefix_sequencer_test.sv
module prefix_sequencer_test;
  logic        clk = 1'b0;
  logic        rstN, start;
  logic [15:0] startPc;
  logic [7:0]  progBank, romBank;
  logic [23:0] pmAddr;
  logic [7:0]  pmData;
  logic        dispValid;
  logic [9:0]  dispIdx;
  logic [3:0]  dispSrc, dispDst;
  logic        exWrite, exBranch, exStop;
  logic [15:0] exResult;
  logic [7:0]  exOffset;
  logic        romReq;
  logic [23:0] romAddr;
  logic        romValid;
  logic [7:0]  romData, romBuf;
  logic [15:0] status;

  logic [7:0] mem [0:255];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign pmData = mem[pmAddr[7:0]];

  prefix_sequencer uut (
    .clk(clk), .rstN(rstN), .start(start), .startPc(startPc), .progBank(progBank),
    .romBank(romBank), .pmAddr(pmAddr), .pmData(pmData), .dispValid(dispValid),
    .dispIdx(dispIdx), .dispSrc(dispSrc), .dispDst(dispDst), .exWrite(exWrite),
    .exResult(exResult), .exBranch(exBranch), .exOffset(exOffset), .exStop(exStop),
    .romReq(romReq), .romAddr(romAddr), .romValid(romValid), .romData(romData),
    .romBuf(romBuf), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic launch(input logic [15:0] pc);
    startPc = pc;
    start = 1'b1;
    tick();
    start = 1'b0;
    chk("R2 fill addr", pmAddr, {progBank, pc});
    chk("R2 fill idle", dispValid, 1'b0);
    tick();
    chk("R2 first valid", dispValid, 1'b1);
    chk("R2 prefetch addr", pmAddr, {progBank, pc + 16'd1});
  endtask

  task automatic stopHere();
    exStop = 1'b1;
    tick();
    exStop = 1'b0;
    chk("R11 stopped", dispValid, 1'b0);
    chk("R11 run flag", status[5], 1'b0);
  endtask

  task automatic testModes();
    mem[8'h10] = 8'h3D; mem[8'h11] = 8'h05; mem[8'h12] = 8'h3E;
    mem[8'h13] = 8'h3F; mem[8'h14] = 8'h07;
    launch(16'h0010);
    chk("R2 first opcode", dispIdx, 10'h03D);
    tick();
    chk("R3 mode1 index", dispIdx, 10'h105);
    chk("R4 mode1 status", status, 16'h0120);
    tick();
    chk("R8 cleared index", dispIdx, 10'h03E);
    chk("R8 cleared status", status, 16'h0020);
    tick();
    chk("R3 mode2 index", dispIdx, 10'h23F);
    tick();
    chk("R4 mode3 index", dispIdx, 10'h307);
    chk("R4 mode3 status", status, 16'h0320);
    stopHere();
    chk("R8 status after stop", status, 16'h0000);
  endtask

  task automatic testSelectors();
    mem[8'h30] = 8'h16; mem[8'h31] = 8'hB3; mem[8'h32] = 8'h3D; mem[8'h33] = 8'h40;
    mem[8'h34] = 8'h25; mem[8'h35] = 8'h17; mem[8'h36] = 8'h28; mem[8'h37] = 8'hB2;
    mem[8'h38] = 8'h01;
    launch(16'h0030);
    chk("R6 to idx", dispIdx, 10'h016);
    tick();
    chk("R6 dst set", {dispSrc, dispDst}, 8'h06);
    tick();
    chk("R6 src set", {dispSrc, dispDst}, 8'h36);
    tick();
    chk("R6 idx after prefixes", dispIdx, 10'h140);
    chk("R6 kept sel", {dispSrc, dispDst}, 8'h36);
    chk("R6 kept mode", status, 16'h0120);
    tick();
    chk("R8 sel zero", {dispSrc, dispDst}, 8'h00);
    chk("R8 status zero", status, 16'h0020);
    tick();
    chk("R5 pair status", status, 16'h1020);
    chk("R7 move dst", {dispSrc, dispDst}, 8'h57);
    tick();
    chk("R7 move cleared", {dispSrc, dispDst}, 8'h00);
    chk("R7 move cleared status", status, 16'h0020);
    tick();
    chk("R7 move src", {dispSrc, dispDst}, 8'h28);
    tick();
    chk("R8 after move", {dispSrc, dispDst}, 8'h00);
    stopHere();
  endtask

  task automatic testBranch();
    mem[8'h60] = 8'h05; mem[8'h61] = 8'h06; mem[8'h71] = 8'h09; mem[8'h72] = 8'h0A;
    mem[8'h73] = 8'h0B; mem[8'h63] = 8'h0C; mem[8'h64] = 8'h01;
    launch(16'h0060);
    exBranch = 1'b1; exOffset = 8'h10;
    tick();
    exBranch = 1'b0;
    chk("R9 delay slot runs", dispIdx, 10'h006);
    chk("R9 forward target", pmAddr, 24'h420071);
    tick();
    chk("R9 target opcode", dispIdx, 10'h009);
    tick();
    chk("R9 second branch op", dispIdx, 10'h00A);
    exBranch = 1'b1; exOffset = 8'hF0;
    tick();
    exBranch = 1'b0;
    chk("R9 back delay slot", dispIdx, 10'h00B);
    chk("R9 backward target", pmAddr, 24'h420063);
    tick();
    chk("R9 back target opcode", dispIdx, 10'h00C);
    tick();
    stopHere();
  endtask

  task automatic testRomBuffer();
    mem[8'h80] = 8'h2E; mem[8'h81] = 8'h55; mem[8'h82] = 8'h00; mem[8'h83] = 8'h00;
    mem[8'h84] = 8'h00; mem[8'h85] = 8'h23; mem[8'h86] = 8'h56; mem[8'h87] = 8'h01;
    launch(16'h0080);
    chk("R10 idle before", romReq, 1'b0);
    tick();
    chk("R10 dst 14", dispDst, 4'd14);
    exWrite = 1'b1; exResult = 16'h1234;
    tick();
    exWrite = 1'b0;
    chk("R10 request", romReq, 1'b1);
    chk("R10 address", romAddr, 24'h7A1234);
    chk("R10 pending flag", status, 16'h0060);
    tick();
    chk("R10 still pending", status[6], 1'b1);
    romValid = 1'b1; romData = 8'hA5;
    tick();
    romValid = 1'b0;
    chk("R10 buffer byte", romBuf, 8'hA5);
    chk("R10 request done", romReq, 1'b0);
    chk("R10 flag clear", status, 16'h0020);
    tick();
    tick();
    chk("R12 other dst", dispDst, 4'd3);
    exWrite = 1'b1; exResult = 16'h9999;
    tick();
    exWrite = 1'b0;
    chk("R12 no request", romReq, 1'b0);
    chk("R12 buffer kept", romBuf, 8'hA5);
    stopHere();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rstN = 1'b0; start = 1'b0; startPc = '0; progBank = 8'h42; romBank = 8'h7A;
    exWrite = 1'b0; exResult = '0; exBranch = 1'b0; exOffset = '0; exStop = 1'b0;
    romValid = 1'b0; romData = '0;
    repeat (3) @(negedge clk);
    chk("R1 status", status, 16'h0000);
    chk("R1 dispValid", dispValid, 1'b0);
    chk("R1 romReq", romReq, 1'b0);
    rstN = 1'b1;
    tick();
    testModes();
    testSelectors();
    testBranch();
    testRomBuffer();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule